// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This unit carries out one single-bit instruction at a time against a 256-entry bit space. Each command holds an operation code, an 8-bit bit address and the current carry flag. The unit turns the bit address into a byte address and a bit index. When the operation needs the addressed bit, it reads that byte over a plain synchronous byte-memory port. It then computes the new carry and a branch-taken flag. When the operation changes the bit, it writes the byte back with only that bit altered.

The lower half of the bit space covers a 16-byte RAM window. The upper half covers only those register bytes whose address is a multiple of 8, so no other register byte can ever be reached. Branch targets are not computed here. The unit only reports whether a conditional jump would be taken. The memory behind the port belongs to the surrounding design.

Commands arrive on a valid/ready channel. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the unit is idle with no result pending. The result is presented on a valid/ready channel. `rsp_valid` stays high with stable fields until `rsp_ready` is seen high on a clock edge. Until then no new command is taken, which is how back-pressure from the result side reaches the command side.

Top module: `bit_processor`

## Requirements
- R1: Bit addresses 0x00 to 0x7F select byte 0x20 + (address >> 3), bit (address & 7). Every access to this region stays within bytes 0x20 to 0x2F.
- R2: Bit addresses 0x80 to 0xFF select byte (address & 0xF8), bit (address & 7). Every memory access in this region uses a byte address that is a multiple of 8.
- R3: A command is accepted when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from acceptance until the result is taken. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_carry` and `rsp_taken` hold steady.
- R4: Timing, counted in cycles after the accepting edge:
  - A memory operation drives `mem_rd_en` in cycle 1. It expects `mem_rdata` in cycle 2. When it writes, it drives `mem_wr_en` in cycle 3.
  - `busy` is high from cycle 1 until the last cycle before `rsp_valid`.
  - `rsp_valid` rises in cycle 4 for a writing operation, in cycle 3 for a reading-only operation, and in cycle 2 for a carry-only operation.
- R5: Op 0 (bit to carry) returns the addressed bit as the carry and does not write memory.
- R6: Op 1 (carry to bit) writes the byte with only the addressed bit replaced by the carry. The returned carry equals the input carry.
- R7: Ops 5, 6 and 7 (clear, set or invert the bit) write the byte with only the addressed bit changed. All other bits are preserved and the carry is returned unchanged.
- R8: Ops 2, 3 and 4 clear, set or invert the carry without any memory read or write. The bit address is ignored.
- R9: Ops 8 to 11 return one of four carries: carry AND bit (8), carry AND NOT bit (9), carry OR bit (10), or carry OR NOT bit (11). None of them writes memory.
- R10: Op 12 is taken when the bit is 1, and op 13 when the bit is 0. Op 15 is taken when the carry is 1, and op 16 when the carry is 0. None of them writes memory or changes the carry. Ops 15 and 16 do not read memory.
- R11: Op 14 (test and clear) is taken when the bit is 1 and then writes the byte with that bit cleared. When the bit is 0 it is not taken and nothing is written.
- R12: Op codes 17 to 31 are no-ops. They make no memory access, return the carry unchanged and are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_op | input | 5 | Operation code |
| cmd_bit_addr | input | 8 | Bit address |
| cmd_carry | input | 1 | Carry flag before the operation |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_carry | output | 1 | Carry flag after the operation |
| rsp_taken | output | 1 | Conditional jump would be taken |
| busy | output | 1 | Memory sequence in progress |
| mem_addr | output | 8 | Byte address to memory |
| mem_rd_en | output | 1 | Read strobe; data is due the next cycle |
| mem_rdata | input | 8 | Read data |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |

## Verification
The bench surrounds every command with a fully patterned memory. A decode that reaches an unaligned register byte, or that wanders outside the RAM window, therefore shows up as a corrupted neighbour or a wrong read value. The bench also targets the opposite bit values of the test-and-clear jump. A design that clears regardless of the bit would write when bit = 0, and one that forgets the clear would leave bit = 1 set.

Inverted-operand logic ops are driven with both bit values, so swapping the plain and inverted forms changes the carry. Carry-only ops and unused codes are checked for zero memory strobes. The result channel is held stalled while the bench watches that the fields stay frozen and that no new command is accepted.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

  localparam int OP_W = 5;

  localparam logic [OP_W-1:0] OP_BIT2C  = 5'd0;
  localparam logic [OP_W-1:0] OP_C2BIT  = 5'd1;
  localparam logic [OP_W-1:0] OP_CLRC   = 5'd2;
  localparam logic [OP_W-1:0] OP_SETC   = 5'd3;
  localparam logic [OP_W-1:0] OP_CPLC   = 5'd4;
  localparam logic [OP_W-1:0] OP_CLRB   = 5'd5;
  localparam logic [OP_W-1:0] OP_SETB   = 5'd6;
  localparam logic [OP_W-1:0] OP_CPLB   = 5'd7;
  localparam logic [OP_W-1:0] OP_ANDC   = 5'd8;
  localparam logic [OP_W-1:0] OP_ANDNC  = 5'd9;
  localparam logic [OP_W-1:0] OP_ORC    = 5'd10;
  localparam logic [OP_W-1:0] OP_ORNC   = 5'd11;
  localparam logic [OP_W-1:0] OP_JBSET  = 5'd12;
  localparam logic [OP_W-1:0] OP_JBCLR  = 5'd13;
  localparam logic [OP_W-1:0] OP_JBTC   = 5'd14;
  localparam logic [OP_W-1:0] OP_JCY    = 5'd15;
  localparam logic [OP_W-1:0] OP_JNCY   = 5'd16;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_EVAL = 3'd2,
    ST_WR   = 3'd3,
    ST_RSP  = 3'd4
  } bp_state_e;

  // operations that need the addressed byte fetched
  function automatic logic op_reads_mem(input logic [OP_W-1:0] op);
    return (op <= OP_JBTC) && (op != OP_CLRC) && (op != OP_SETC) && (op != OP_CPLC);
  endfunction

  // operations whose result lands in memory and never in carry
  function automatic logic op_is_bitwrite(input logic [OP_W-1:0] op);
    return (op == OP_C2BIT) || (op == OP_CLRB) || (op == OP_SETB) || (op == OP_CPLB);
  endfunction

endpackage

// File: rtl/bp_addr_decode.sv
module bp_addr_decode #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20
) (
  input  logic [ADDR_W-1:0] bit_addr,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              is_sfr
);
  localparam int WIN_W = ADDR_W - 1 - IDX_W;

  logic [WIN_W-1:0] win_off;

  assign is_sfr  = bit_addr[ADDR_W-1];
  assign bit_idx = bit_addr[IDX_W-1:0];
  assign win_off = bit_addr[ADDR_W-2:IDX_W];

  always_comb begin
    if (is_sfr) byte_addr = {bit_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
    else        byte_addr = RAM_BASE + ADDR_W'(win_off);
  end
endmodule

// File: rtl/bp_alu.sv
module bp_alu
  import bitproc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [OP_W-1:0]   op,
  input  logic              carry_in,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [IDX_W-1:0]  idx,
  output logic              carry_out,
  output logic              taken,
  output logic              wr_req,
  output logic [BYTE_W-1:0] byte_out
);
  logic cur_bit;
  logic new_bit;

  assign cur_bit = byte_in[idx];

  always_comb begin
    carry_out = carry_in;
    taken     = 1'b0;
    wr_req    = 1'b0;
    new_bit   = cur_bit;
    case (op)
      OP_BIT2C: carry_out = cur_bit;
      OP_C2BIT: begin new_bit = carry_in; wr_req = 1'b1; end
      OP_CLRC:  carry_out = 1'b0;
      OP_SETC:  carry_out = 1'b1;
      OP_CPLC:  carry_out = ~carry_in;
      OP_CLRB:  begin new_bit = 1'b0; wr_req = 1'b1; end
      OP_SETB:  begin new_bit = 1'b1; wr_req = 1'b1; end
      OP_CPLB:  begin new_bit = ~cur_bit; wr_req = 1'b1; end
      OP_ANDC:  carry_out = carry_in & cur_bit;
      OP_ANDNC: carry_out = carry_in & ~cur_bit;
      OP_ORC:   carry_out = carry_in | cur_bit;
      OP_ORNC:  carry_out = carry_in | ~cur_bit;
      OP_JBSET: taken = cur_bit;
      OP_JBCLR: taken = ~cur_bit;
      OP_JBTC: begin
        taken = cur_bit;
        if (cur_bit) begin
          new_bit = 1'b0;
          wr_req  = 1'b1;
        end
      end
      OP_JCY:   taken = carry_in;
      OP_JNCY:  taken = ~carry_in;
      default: ;
    endcase
  end

  // per-bit merge: only the indexed lane takes the new value
  for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
    assign byte_out[g] = (idx == IDX_W'(g)) ? new_bit : byte_in[g];
  end
endmodule

// File: rtl/bp_seq.sv
module bp_seq
  import bitproc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic              cmd_carry,
  input  logic [ADDR_W-1:0] dec_byte_addr,
  input  logic [IDX_W-1:0]  dec_idx,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_carry,
  output logic              rsp_taken,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_wr_en,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [OP_W-1:0]   alu_op,
  output logic              alu_carry,
  output logic [IDX_W-1:0]  alu_idx,
  input  logic              alu_carry_out,
  input  logic              alu_taken,
  input  logic              alu_wr,
  input  logic [BYTE_W-1:0] alu_byte
);
  bp_state_e         state;
  logic [OP_W-1:0]   op_q;
  logic              carry_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] wbyte_q;
  logic [BYTE_W-1:0] rbyte_q;
  logic              rc_q;
  logic              rt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= '0;
      carry_q <= 1'b0;
      addr_q  <= '0;
      idx_q   <= '0;
      wbyte_q <= '0;
      rbyte_q <= '0;
      rc_q    <= 1'b0;
      rt_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          op_q    <= cmd_op;
          carry_q <= cmd_carry;
          addr_q  <= dec_byte_addr;
          idx_q   <= dec_idx;
          state   <= op_reads_mem(cmd_op) ? ST_RD : ST_EVAL;
        end
        ST_RD:   state <= ST_EVAL;
        ST_EVAL: begin
          rc_q    <= alu_carry_out;
          rt_q    <= alu_taken;
          wbyte_q <= alu_byte;
          rbyte_q <= mem_rdata;
          state   <= alu_wr ? ST_WR : ST_RSP;
        end
        ST_WR:   state <= ST_RSP;
        ST_RSP:  if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state == ST_RD) || (state == ST_EVAL) || (state == ST_WR);
  assign rsp_valid = (state == ST_RSP);
  assign rsp_carry = rc_q;
  assign rsp_taken = rt_q;
  assign mem_addr  = addr_q;
  assign mem_rd_en = (state == ST_RD);
  assign mem_wr_en = (state == ST_WR);
  assign mem_wdata = wbyte_q;
  assign alu_op    = op_q;
  assign alu_carry = carry_q;
  assign alu_idx   = idx_q;

  assert_rsp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_carry) && $stable(rsp_taken)));

  assert_no_accept_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || busy) |-> !cmd_ready);

  assert_wr_after_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en, 2));

  assert_one_bit_changed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($countones(mem_wdata ^ rbyte_q) <= 1));

  assert_carry_only_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !op_reads_mem(cmd_op)) |=> !mem_rd_en);

  assert_bitwrite_keeps_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_is_bitwrite(op_q)) |-> (rsp_carry == carry_q));

  assert_jbtc_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && op_q == OP_JBTC) |-> (rt_q && !mem_wdata[idx_q]));
endmodule

// File: rtl/bit_processor.sv
module bit_processor
  import bitproc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [ADDR_W-1:0] cmd_bit_addr,
  input  logic              cmd_carry,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_carry,
  output logic              rsp_taken,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_wr_en,
  output logic [BYTE_W-1:0] mem_wdata
);
  localparam int IDX_W     = $clog2(BYTE_W);
  localparam int RAM_BYTES = (1 << (ADDR_W - 1)) / BYTE_W;

  logic [ADDR_W-1:0] dec_byte_addr;
  logic [IDX_W-1:0]  dec_idx;
  logic              dec_is_sfr;
  logic [OP_W-1:0]   alu_op;
  logic              alu_carry;
  logic [IDX_W-1:0]  alu_idx;
  logic              alu_carry_out;
  logic              alu_taken;
  logic              alu_wr;
  logic [BYTE_W-1:0] alu_byte;

  bp_addr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .RAM_BASE(RAM_BASE)) u_dec (
    .bit_addr  (cmd_bit_addr),
    .byte_addr (dec_byte_addr),
    .bit_idx   (dec_idx),
    .is_sfr    (dec_is_sfr)
  );

  bp_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_op        (cmd_op),
    .cmd_carry     (cmd_carry),
    .dec_byte_addr (dec_byte_addr),
    .dec_idx       (dec_idx),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_carry     (rsp_carry),
    .rsp_taken     (rsp_taken),
    .busy          (busy),
    .mem_addr      (mem_addr),
    .mem_rd_en     (mem_rd_en),
    .mem_rdata     (mem_rdata),
    .mem_wr_en     (mem_wr_en),
    .mem_wdata     (mem_wdata),
    .alu_op        (alu_op),
    .alu_carry     (alu_carry),
    .alu_idx       (alu_idx),
    .alu_carry_out (alu_carry_out),
    .alu_taken     (alu_taken),
    .alu_wr        (alu_wr),
    .alu_byte      (alu_byte)
  );

  bp_alu #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_alu (
    .op        (alu_op),
    .carry_in  (alu_carry),
    .byte_in   (mem_rdata),
    .idx       (alu_idx),
    .carry_out (alu_carry_out),
    .taken     (alu_taken),
    .wr_req    (alu_wr),
    .byte_out  (alu_byte)
  );

  // decoded addresses must land in the RAM window or on an aligned register byte
  assert_access_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd_en || mem_wr_en) && !mem_addr[ADDR_W-1]) |->
      ((mem_addr >= RAM_BASE) && (mem_addr < RAM_BASE + ADDR_W'(RAM_BYTES))));

  assert_sfr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd_en || mem_wr_en) && mem_addr[ADDR_W-1]) |-> (mem_addr[IDX_W-1:0] == '0));

  assert_sfr_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && dec_is_sfr) |-> dec_byte_addr[ADDR_W-1]);
endmodule

// File: tb/sim_bit_processor.sv
`timescale 1ns/1ps
module sim_bit_processor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [4:0] cmd_op = '0;
  logic [7:0] cmd_bit_addr = '0;
  logic       cmd_carry = 1'b0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic       rsp_carry, rsp_taken, busy;
  logic [7:0] mem_addr;
  logic       mem_rd_en, mem_wr_en;
  logic [7:0] mem_rdata = '0;
  logic [7:0] mem_wdata;

  logic [7:0] mem [0:255];
  logic       ld_en = 1'b0;
  logic [7:0] ld_addr = '0, ld_data = '0;
  int rd_cnt = 0, wr_cnt = 0;
  int n_pass = 0, n_total = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bit_processor u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bit_addr(cmd_bit_addr), .cmd_carry(cmd_carry),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_carry(rsp_carry),
    .rsp_taken(rsp_taken), .busy(busy), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr_en) begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    if (mem_rd_en) begin mem_rdata <= mem[mem_addr]; rd_cnt <= rd_cnt + 1; end
  end

  // {op, bit addr, carry in, initial byte, exp carry, exp taken, exp write, exp byte}
  localparam int NV = 26;
  localparam logic [32:0] VECS [0:NV-1] = '{
    {5'd0,  8'h05, 1'b0, 8'h20, 1'b1, 1'b0, 1'b0, 8'h20},
    {5'd0,  8'h7F, 1'b1, 8'h7F, 1'b0, 1'b0, 1'b0, 8'h7F},
    {5'd1,  8'h0A, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h04},
    {5'd1,  8'h0A, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1, 8'hFB},
    {5'd5,  8'h8B, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 8'hF7},
    {5'd6,  8'hD3, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h08},
    {5'd7,  8'hE7, 1'b1, 8'h80, 1'b1, 1'b0, 1'b1, 8'h00},
    {5'd7,  8'h31, 1'b0, 8'h55, 1'b0, 1'b0, 1'b1, 8'h57},
    {5'd8,  8'h10, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 8'h01},
    {5'd8,  8'h10, 1'b1, 8'hFE, 1'b0, 1'b0, 1'b0, 8'hFE},
    {5'd9,  8'h10, 1'b1, 8'hFE, 1'b1, 1'b0, 1'b0, 8'hFE},
    {5'd10, 8'h42, 1'b0, 8'h04, 1'b1, 1'b0, 1'b0, 8'h04},
    {5'd11, 8'h42, 1'b0, 8'h04, 1'b0, 1'b0, 1'b0, 8'h04},
    {5'd11, 8'h42, 1'b1, 8'h04, 1'b1, 1'b0, 1'b0, 8'h04},
    {5'd12, 8'hF5, 1'b0, 8'h20, 1'b0, 1'b1, 1'b0, 8'h20},
    {5'd12, 8'hF5, 1'b1, 8'hDF, 1'b1, 1'b0, 1'b0, 8'hDF},
    {5'd13, 8'hF5, 1'b0, 8'hDF, 1'b0, 1'b1, 1'b0, 8'hDF},
    {5'd14, 8'h99, 1'b1, 8'h02, 1'b1, 1'b1, 1'b1, 8'h00},
    {5'd14, 8'h99, 1'b0, 8'hFD, 1'b0, 1'b0, 1'b0, 8'hFD},
    {5'd2,  8'h00, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 8'h11},
    {5'd3,  8'h00, 1'b0, 8'h11, 1'b1, 1'b0, 1'b0, 8'h11},
    {5'd4,  8'h00, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 8'h11},
    {5'd15, 8'h00, 1'b1, 8'h11, 1'b1, 1'b1, 1'b0, 8'h11},
    {5'd16, 8'h00, 1'b1, 8'h11, 1'b1, 1'b0, 1'b0, 8'h11},
    {5'd16, 8'h00, 1'b0, 8'h11, 1'b0, 1'b1, 1'b0, 8'h11},
    {5'd20, 8'h35, 1'b1, 8'hAA, 1'b1, 1'b0, 1'b0, 8'hAA}
  };

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] tgt_byte(input logic [7:0] a);
    return a[7] ? {a[7:3], 3'b000} : (8'h20 + {4'h0, a[6:3]});
  endfunction

  function automatic bit needs_read(input logic [4:0] op);
    return (op <= 5'd14) && !(op inside {5'd2, 5'd3, 5'd4});
  endfunction

  function automatic string req_of(input logic [4:0] op);
    case (op)
      5'd0: return "R5";
      5'd1: return "R6";
      5'd2, 5'd3, 5'd4: return "R8";
      5'd5, 5'd6, 5'd7: return "R7";
      5'd8, 5'd9, 5'd10, 5'd11: return "R9";
      5'd12, 5'd13, 5'd15, 5'd16: return "R10";
      5'd14: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  task automatic load_mem(input logic [7:0] tgt, input logic [7:0] init);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 8'(i); ld_data = (8'(i) == tgt) ? init : pat(i);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_cmd(input logic [4:0] op, input logic [7:0] a, input logic c,
                         output logic oc, output logic ot, output int lat, output int bsy);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bit_addr = a; cmd_carry = c;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1; bsy = 0;
    while (!rsp_valid && lat < 50) begin
      if (busy) bsy++;
      @(negedge clk);
      lat++;
    end
    oc = rsp_carry; ot = rsp_taken;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end

  initial begin
    logic oc, ot;
    int lat, bsy, r0, w0;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R3", "reset cmd_ready", cmd_ready, 1);
    chk(!rsp_valid && !busy, "R4", "reset rsp_valid/busy", {rsp_valid, busy}, 0);
    chk(!mem_rd_en && !mem_wr_en, "R4", "reset strobes", {mem_rd_en, mem_wr_en}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [4:0] op; logic [7:0] a, init, eb, tb; logic ci, ec, et, ew;
      int exp_lat;
      {op, a, ci, init, ec, et, ew, eb} = VECS[v];
      tb = tgt_byte(a);
      load_mem(tb, init);
      r0 = rd_cnt; w0 = wr_cnt;
      run_cmd(op, a, ci, oc, ot, lat, bsy);
      @(negedge clk);
      chk(oc == ec, req_of(op), $sformatf("v%0d carry", v), oc, ec);
      chk(ot == et, req_of(op), $sformatf("v%0d taken", v), ot, et);
      chk(mem[tb] == eb, (tb[7] ? "R2" : "R1"), $sformatf("v%0d byte %0h", v, tb), mem[tb], eb);
      chk((wr_cnt - w0) == int'(ew), req_of(op), $sformatf("v%0d writes", v), wr_cnt - w0, ew);
      chk((rd_cnt - r0) == int'(needs_read(op)), req_of(op), $sformatf("v%0d reads", v),
          rd_cnt - r0, needs_read(op));
      begin
        int bad = 0;
        for (int i = 0; i < 256; i++)
          if (8'(i) != tb && mem[i] != pat(i)) bad++;
        chk(bad == 0, "R2", $sformatf("v%0d neighbours untouched", v), bad, 0);
      end
      exp_lat = ew ? 4 : (needs_read(op) ? 3 : 2);
      chk(lat == exp_lat, "R4", $sformatf("v%0d latency", v), lat, exp_lat);
      chk(bsy == exp_lat - 1, "R4", $sformatf("v%0d busy cycles", v), bsy, exp_lat - 1);
    end

    // back-pressure on the result channel
    load_mem(8'h2F, 8'h80);
    rsp_ready = 1'b0;
    run_cmd(5'd12, 8'h7F, 1'b0, oc, ot, lat, bsy);
    chk(ot == 1'b1, "R10", "stalled taken", ot, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && !cmd_ready, "R3", "stall holds valid, blocks cmd", {rsp_valid, cmd_ready}, 2'b10);
      chk(rsp_taken == ot && rsp_carry == oc, "R3", "stall fields stable", {rsp_carry, rsp_taken}, {oc, ot});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && cmd_ready, "R3", "release returns idle", {rsp_valid, cmd_ready}, 2'b01);

    // test-and-clear on the top register bit of the highest aligned byte
    load_mem(8'hF8, 8'hFF);
    run_cmd(5'd14, 8'hFF, 1'b0, oc, ot, lat, bsy);
    @(negedge clk);
    chk(mem[8'hF8] == 8'h7F && ot, "R11", "clear bit 7 of F8", mem[8'hF8], 8'h7F);

    done = 1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule